// File: doc/BRIEF.md
# Eight-Channel Linear Attenuator with Clickless Mute

This block scales eight channels of two's-complement audio, grouped as four stereo pairs, on their way to the output converters. Every channel has its own 10-bit linear gain code, and the sample is multiplied by code/1024. The one exception is the all-ones code, which passes the sample through unchanged. Each channel also has a mute request. The gain the datapath actually applies does not jump to a new value. It moves one step per accepted sample toward its target, so a mute, an unmute or a new code never causes a sudden step in level.

Samples enter as one wide word holding all eight channels, qualified by a single valid strobe. The word length can be 16, 20 or 24 bits, and shorter words sit left-aligned in a 24-bit lane. A replicate control feeds the first pair's left and right samples to every pair. With it, a source that only fills the first pair, for example at a doubled sample rate, can drive all four pairs. Each channel keeps its own gain and mute in this mode.

Top module: `multichan_atten`

## Requirements
- R1: For each channel i, with applied gain g (0..1022) and input sample x (signed 24-bit), the output is floor(x*g/1024), taken as signed 24-bit.
- R2: An applied gain of 1023 gives an output equal to the (word-length-masked) input, with no rounding.
- R3: The applied gain changes by at most one step, and only at an edge where in_valid is high. Without in_valid it holds, even if the code or mute changes.
- R4: While a channel's mute bit is high, its applied gain falls by one per accepted sample until it reaches 0, and the output is then 0.
- R5: When the mute bit is low and the applied gain is below the channel's code, the gain rises by one per accepted sample until it equals the code.
- R6: A code lowered below the applied gain while unmuted is approached downward at one step per accepted sample. The gain never jumps.
- R7: word_len 0 selects 16-bit words (bits 23:8), 1 selects 20-bit words (bits 23:4), and 2 or 3 selects 24 bits. Input bits below the word are ignored, and output bits below it are zero. The result is rounded toward negative infinity.
- R8: With replicate high, the even channels take channel 0's input and the odd channels take channel 1's input. Each channel still uses its own gain.
- R9: out_valid goes high exactly two clock edges after the edge that takes in a sample. Outputs hold their last value while no new result is produced.
- R10: After reset, out_valid is 0, all outputs are 0, and every applied gain is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for all channels |
| in_samples | input | 192 | Channel i at bits [24i+23:24i], two's complement, left-aligned |
| gain_codes | input | 80 | Channel i gain code at bits [10i+9:10i] |
| mute | input | 8 | Mute request, one bit per channel |
| replicate | input | 1 | Feed pair 0 to all pairs |
| word_len | input | 2 | 0: 16-bit, 1: 20-bit, 2/3: 24-bit |
| out_valid | output | 1 | Result strobe |
| out_samples | output | 192 | Scaled samples, same layout as input |

## Verification
A sample is taken in at the edge where in_valid is high, and its scaled result and out_valid appear after the second edge. The gain used for a sample is the applied gain held just before the edge that takes it in; the ramp step happens at that same edge. The bench drives each sample on a falling edge and lowers in_valid after the first rising edge. There it confirms out_valid is still low. It reads the results on the falling edge after the second rising edge. A bench model of the applied gain advances only when a sample is sent, so idle cycles in which the controls change are checked against an unchanged gain.

// File: rtl/atten_pkg.sv
package atten_pkg;
  typedef enum logic [1:0] {
    WL_16  = 2'd0,
    WL_20  = 2'd1,
    WL_24  = 2'd2,
    WL_24X = 2'd3
  } wlen_e;
endpackage

// File: rtl/gain_ramp.sv
module gain_ramp #(
  parameter int GAIN_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              mute,
  input  logic [GAIN_W-1:0] code,
  output logic [GAIN_W-1:0] eff
);
  localparam logic [GAIN_W-1:0] ONE = GAIN_W'(1);

  logic [GAIN_W-1:0] target;

  assign target = mute ? '0 : code;

  always_ff @(posedge clk) begin
    if (rst) begin
      eff <= '0;
    end else if (step_en) begin
      if (target > eff)      eff <= eff + ONE;
      else if (target < eff) eff <= eff - ONE;
    end
  end

  // R3: at most one step per accepted sample
  p_one_step_r3: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (eff == $past(eff) || eff == $past(eff) + ONE || eff == $past(eff) - ONE));
  // R3: no movement without a sample
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(eff));
  // R4: muted gain never rises
  p_mute_down_r4: assert property (@(posedge clk) disable iff (rst)
    (step_en && mute && eff != '0) |=> eff == $past(eff) - ONE);
  // R5: unmuted gain climbs toward code
  p_unmute_up_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && !mute && eff < code) |=> eff == $past(eff) + ONE);
endmodule

// File: rtl/chan_scaler.sv
module chan_scaler #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              fire,
  input  logic [DATA_W-1:0] sample,
  input  logic [GAIN_W-1:0] gain,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] result
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

  logic signed [DATA_W-1:0] s1_x;
  logic        [GAIN_W-1:0] s1_g;
  logic        [DATA_W-1:0] s1_mask;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;
  logic        [DATA_W-1:0] scaled;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_x    <= '0;
      s1_g    <= '0;
      s1_mask <= '1;
    end else if (cap_en) begin
      s1_x    <= sample & mask;
      s1_g    <= gain;
      s1_mask <= mask;
    end
  end

  always_comb begin
    prod    = PROD_W'(s1_x) * $signed({1'b0, s1_g});
    shifted = prod >>> GAIN_W;
    if (s1_g == GAIN_MAX) scaled = s1_x;
    else                  scaled = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       result <= '0;
    else if (fire) result <= scaled & s1_mask;
  end

  // R2: full code is a pass-through
  p_unity_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && s1_g == GAIN_MAX) |=> result == $past(s1_x));
  // R4: zero gain gives silence
  p_zero_gain_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && s1_g == '0) |=> result == '0);
  // R7: bits below the word are clear
  p_word_mask_r7: assert property (@(posedge clk) disable iff (rst)
    fire |=> (result & ~$past(s1_mask)) == '0);
  // R9: output holds between results
  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(result));
endmodule

// File: rtl/multichan_atten.sv
module multichan_atten #(
  parameter int NCH    = 8,
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [NCH*DATA_W-1:0]   in_samples,
  input  logic [NCH*GAIN_W-1:0]   gain_codes,
  input  logic [NCH-1:0]          mute,
  input  logic                    replicate,
  input  logic [1:0]              word_len,
  output logic                    out_valid,
  output logic [NCH*DATA_W-1:0]   out_samples
);
  import atten_pkg::*;

  localparam int SH16 = DATA_W - 16;
  localparam int SH20 = DATA_W - 20;
  localparam logic [DATA_W-1:0] FULL = '1;

  logic [DATA_W-1:0] mask;
  logic              v1;

  always_comb begin
    unique case (wlen_e'(word_len))
      WL_16:   mask = FULL << SH16;
      WL_20:   mask = FULL << SH20;
      default: mask = FULL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int SRC = i % 2;
    logic [DATA_W-1:0] src;
    logic [GAIN_W-1:0] eff;

    assign src = replicate ? in_samples[SRC*DATA_W +: DATA_W]
                           : in_samples[i*DATA_W +: DATA_W];

    gain_ramp #(.GAIN_W(GAIN_W)) i_ramp (
      .clk     (clk),
      .rst     (rst),
      .step_en (in_valid),
      .mute    (mute[i]),
      .code    (gain_codes[i*GAIN_W +: GAIN_W]),
      .eff     (eff)
    );

    chan_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) i_scale (
      .clk    (clk),
      .rst    (rst),
      .cap_en (in_valid),
      .fire   (v1),
      .sample (src),
      .gain   (eff),
      .mask   (mask),
      .result (out_samples[i*DATA_W +: DATA_W])
    );
  end

  // R9: a result only follows a sample two edges back
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
endmodule

// File: tb/test_multichan_atten.sv
module test_multichan_atten;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [191:0] in_samples = '0;
  logic [79:0]  gain_codes = '0;
  logic [7:0]   mute = '0;
  logic         replicate = 1'b0;
  logic [1:0]   word_len = 2'd2;
  logic         out_valid;
  logic [191:0] out_samples;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int eff_m [8];
  logic [23:0] smp [8];

  always #5 clk = ~clk;

  multichan_atten i_multichan_atten (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
    .gain_codes(gain_codes), .mute(mute), .replicate(replicate),
    .word_len(word_len), .out_valid(out_valid), .out_samples(out_samples)
  );

  function automatic logic [23:0] exp_out(logic [23:0] x, int g, logic [1:0] wl);
    logic [23:0] m, xm, r;
    longint p;
    m  = (wl == 2'd0) ? 24'hFFFF00 : (wl == 2'd1) ? 24'hFFFFF0 : 24'hFFFFFF;
    xm = x & m;
    if (g == 1023) r = xm;
    else begin
      p = longint'($signed(xm)) * g;
      p = p >>> 10;
      r = p[23:0];
    end
    return r & m;
  endfunction

  task automatic check(string tag, logic [191:0] act, logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_code(int ch, int c);
    gain_codes[ch*10 +: 10] = 10'(c);
  endtask

  task automatic send(string tag, bit lat_chk);
    logic [191:0] bus, exp;
    int tgt;
    for (int i = 0; i < 8; i++) bus[i*24 +: 24] = smp[i];
    for (int i = 0; i < 8; i++) begin
      exp[i*24 +: 24] = exp_out(replicate ? smp[i%2] : smp[i], eff_m[i], word_len);
      tgt = mute[i] ? 0 : int'(gain_codes[i*10 +: 10]);
      if (tgt > eff_m[i]) eff_m[i]++;
      else if (tgt < eff_m[i]) eff_m[i]--;
    end
    @(negedge clk); in_valid = 1'b1; in_samples = bus;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    if (lat_chk) check("R9 valid early", {191'd0, out_valid}, 192'd0);
    @(posedge clk); @(negedge clk);
    if (lat_chk) check("R9 valid due", {191'd0, out_valid}, 192'd1);
    check(tag, out_samples, exp);
  endtask

  task automatic rand_smp();
    for (int i = 0; i < 8; i++) smp[i] = 24'($urandom);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [191:0] held;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) eff_m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10 reset valid", {191'd0, out_valid}, 192'd0);
    check("R10 reset data", out_samples, 192'd0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) set_code(i, 1023);
    // R10: first sample sees zero gain
    rand_smp(); send("R10 zero start gain", 1);
    // R5: ramp up to full code
    for (int k = 0; k < 1023; k++) begin rand_smp(); send("R5 ramp up", 0); end
    // R2: extremes at unity
    smp = '{24'h800000, 24'h7FFFFF, 24'hFFFFFF, 24'h000001,
            24'h123456, 24'hABCDEF, 24'h400000, 24'hC00000};
    send("R2 unity extremes", 1);
    // R1: fixed codes on the way down (R6)
    for (int i = 0; i < 8; i++) set_code(i, 8 + 5 * i);
    for (int k = 0; k < 1030; k++) begin rand_smp(); send("R6 ramp down to code", 0); end
    smp = '{24'h800000, 24'h7FFFFF, 24'hFFFFFF, 24'h000001,
            24'hFFFC00, 24'h000400, 24'h800001, 24'h7FFC00};
    send("R1 scaled corners", 1);
    // R4: mute all, ramp to silence
    mute = 8'hFF;
    for (int k = 0; k < 50; k++) begin rand_smp(); send("R4 mute ramp", 0); end
    rand_smp(); send("R4 muted silence", 0);
    check("R4 silence", out_samples, 192'd0);
    // R5: unmute returns to code
    mute = 8'h00;
    for (int k = 0; k < 50; k++) begin rand_smp(); send("R5 unmute ramp", 0); end
    // R3: controls change during idle cycles, gain must hold
    mute = 8'hFF; set_code(2, 900);
    repeat (12) @(negedge clk);
    mute = 8'h00; set_code(2, 23);
    rand_smp(); send("R3 idle hold", 0);
    // R9: outputs hold without samples
    held = out_samples;
    repeat (4) @(negedge clk);
    check("R9 hold data", out_samples, held);
    check("R9 hold valid", {191'd0, out_valid}, 192'd0);
    // R7: word lengths, negative values for floor
    word_len = 2'd0;
    smp = '{24'hFFFFFF, 24'h8000FF, 24'h7FFFFF, 24'hFFFF01,
            24'h00FFFF, 24'hF000AA, 24'h0001FF, 24'h800000};
    send("R7 16-bit", 1);
    for (int k = 0; k < 40; k++) begin rand_smp(); send("R7 16-bit rand", 0); end
    word_len = 2'd1;
    for (int k = 0; k < 40; k++) begin rand_smp(); send("R7 20-bit rand", 0); end
    word_len = 2'd3;
    for (int k = 0; k < 20; k++) begin rand_smp(); send("R7 24-bit alias", 0); end
    word_len = 2'd2;
    // R8: replicate
    replicate = 1'b1;
    for (int k = 0; k < 40; k++) begin rand_smp(); send("R8 replicate", 0); end
    replicate = 1'b0;
    // R1: random mix
    for (int k = 0; k < 400; k++) begin
      rand_smp();
      if ($urandom_range(0, 9) == 0) set_code($urandom_range(0, 7), $urandom_range(0, 1023));
      if ($urandom_range(0, 19) == 0) mute = 8'($urandom);
      if ($urandom_range(0, 29) == 0) replicate = ~replicate;
      if ($urandom_range(0, 29) == 0) word_len = 2'($urandom);
      send("R1 random mix", 0);
    end
    finish_run();
  end
endmodule